// File: doc/BRIEF.md
# Panel Self-Refresh State Sequencer

This block walks one display pipe through its self-refresh life cycle. Software writes a small control word that holds an enable bit, a mode field, an active-entry bit and a single-frame-update bit. The sequencer reports a three-bit state code, an in-transition flag and an active flag. The hops that belong to hardware happen on the frame strobe: finishing entry, finishing a single-frame update, and leaving exit.

Leaving self-refresh is a direct jump from the active state to the exit state. The single-frame-update state is never passed through on the way. On that jump the block sends a one-cycle wake request toward the sink. It then waits for the acknowledge before it returns to the inactive state. If the acknowledge does not arrive within a programmable number of frames, the block sets a sticky timeout flag and returns to the inactive state anyway.

A disable write is held back while a transition is in flight. Once the in-transition flag is low, the disable clears every control field in the same cycle and the state returns to disabled.

Top module: `psr_seq_top`

## Requirements
- R1: After reset the state code is 0, all flags and the wake request are low, and every control readback field is 0.
- R2: A write with enable=1 and mode=1 (timer mode) moves the state from 0 to 1. Enable with any other mode value leaves the state at 0.
- R3: In state 1, a write with the entry bit set moves the state to 2. The next frame strobe moves it to 3.
- R4: State 2 holds until a frame strobe arrives. Idle cycles do not advance it.
- R5: In state 3, setting the single-frame-update bit moves the state to 4. The next frame strobe returns it to 3 and clears the readback of that bit.
- R6: Clearing the entry bit in state 3 moves the state directly to 5 and raises the wake request for exactly one cycle.
- R7: In state 5, once the wake acknowledge has been seen, the next frame strobe returns the state to 1. Without the acknowledge the state stays at 5 for fewer frame strobes than the limit.
- R8: When the limit number of frame strobes passes in state 5 without an acknowledge, the state returns to 1 and the timeout flag rises. Only reset clears that flag.
- R9: The active flag is high exactly when the state code is 3 or 4.
- R10: A disable write (enable=0 while enabled) has no effect while the in-transition flag is high. Once the flag drops, the state goes to 0 and the enable, entry, mode and single-frame-update readbacks all become 0 together.
- R11: The in-transition flag is high exactly when the state code is 2, 4 or 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Control word write strobe |
| wr_enable | input | 1 | Enable field of the written word |
| wr_entry | input | 1 | Active-entry field of the written word |
| wr_sfu | input | 1 | Sets the single-frame-update bit when 1 |
| wr_mode | input | MODE_W | Mode field of the written word |
| vblank | input | 1 | Frame strobe, one cycle per frame |
| wake_ack | input | 1 | Sink wake acknowledge |
| timeout_frames | input | TMO_W | Frame limit for the wake wait |
| state_code | output | 3 | Current state code 0..5 |
| in_transition | output | 1 | High while a transition is in flight |
| psr_active | output | 1 | High in state 3 or 4 |
| wake_req | output | 1 | One-cycle wake request pulse |
| wake_timeout | output | 1 | Sticky wake-wait timeout flag |
| rb_enable | output | 1 | Readback of the enable bit |
| rb_entry | output | 1 | Readback of the entry bit |
| rb_sfu | output | 1 | Readback of the single-frame-update bit |
| rb_mode | output | MODE_W | Readback of the mode field |

## Verification
The hardest case to reach is a deferred disable. The disable write has to land while the machine sits in a transitional state, and it must then take effect only on the cycle after a frame strobe finishes that transition. The stimulus first uses up a wake timeout so that the sticky flag is also exercised. It then re-enters state 2, issues the disable write, and checks that the state and the readbacks are unchanged. Finally it sends a frame strobe and checks that every field clears at once.

// File: rtl/psr_seq_pkg.sv
package psr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_ENTER = 3'd2,
    ST_ACT   = 3'd3,
    ST_SFU   = 3'd4,
    ST_EXIT  = 3'd5
  } psr_state_e;

  function automatic logic is_transit(psr_state_e s);
    return (s == ST_ENTER) || (s == ST_SFU) || (s == ST_EXIT);
  endfunction

  function automatic logic is_active(psr_state_e s);
    return (s == ST_ACT) || (s == ST_SFU);
  endfunction
endpackage

// File: rtl/psr_ctl_regs.sv
module psr_ctl_regs #(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic              wr_enable,
  input  logic              wr_entry,
  input  logic              wr_sfu,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              in_trans,
  input  logic              sfu_done,
  output logic              en_q,
  output logic              entry_q,
  output logic              sfu_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              dis_go
);
  logic dis_pend;
  logic wr_ok;

  assign wr_ok  = wr_valid && !dis_pend;
  assign dis_go = dis_pend && !in_trans;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      entry_q  <= 1'b0;
      sfu_q    <= 1'b0;
      mode_q   <= '0;
      dis_pend <= 1'b0;
    end else if (dis_go) begin
      en_q     <= 1'b0;
      entry_q  <= 1'b0;
      sfu_q    <= 1'b0;
      mode_q   <= '0;
      dis_pend <= 1'b0;
    end else begin
      if (wr_ok) begin
        if (!wr_enable && en_q) begin
          dis_pend <= 1'b1;
        end else begin
          en_q    <= wr_enable;
          entry_q <= wr_entry;
          mode_q  <= wr_mode;
        end
      end
      if (wr_ok && wr_enable && wr_sfu) sfu_q <= 1'b1;
      else if (sfu_done)                sfu_q <= 1'b0;
    end
  end
endmodule

// File: rtl/psr_wake_timer.sv
module psr_wake_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_exit,
  input  logic             vblank,
  input  logic             wake_ack,
  input  logic [TMO_W-1:0] limit,
  output logic             exit_done,
  output logic             timeout_q
);
  logic             ack_seen;
  logic [TMO_W-1:0] cnt;
  logic [TMO_W:0]   cnt_inc;
  logic             expire;

  assign cnt_inc   = {1'b0, cnt} + {{TMO_W{1'b0}}, 1'b1};
  assign expire    = cnt_inc >= {1'b0, limit};
  assign exit_done = in_exit && vblank && (ack_seen || expire);

  always_ff @(posedge clk) begin
    if (rst || !in_exit) begin
      ack_seen <= 1'b0;
      cnt      <= '0;
    end else begin
      if (wake_ack) ack_seen <= 1'b1;
      if (vblank)   cnt      <= cnt_inc[TMO_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) timeout_q <= 1'b0;
    else if (in_exit && vblank && !ack_seen && expire) timeout_q <= 1'b1;
  end
endmodule

// File: rtl/psr_state_core.sv
module psr_state_core
  import psr_seq_pkg::*;
#(
  parameter int                MODE_W     = 2,
  parameter logic [MODE_W-1:0] TIMER_MODE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              entry,
  input  logic              sfu,
  input  logic [MODE_W-1:0] mode,
  input  logic              vblank,
  input  logic              dis_go,
  input  logic              exit_done,
  output psr_state_e        state_q,
  output logic              in_trans_q,
  output logic              active_q,
  output logic              wake_q,
  output logic              sfu_done
);
  psr_state_e nxt;
  logic       wake_nxt;

  assign sfu_done = (state_q == ST_SFU) && vblank;

  always_comb begin
    nxt      = state_q;
    wake_nxt = 1'b0;
    if (dis_go) begin
      nxt = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:   if (en && mode == TIMER_MODE) nxt = ST_IDLE;
        ST_IDLE:  if (entry) nxt = ST_ENTER;
        ST_ENTER: if (vblank) nxt = ST_ACT;
        ST_ACT: begin
          if (!entry) begin
            nxt      = ST_EXIT;
            wake_nxt = 1'b1;
          end else if (sfu) begin
            nxt = ST_SFU;
          end
        end
        ST_SFU:   if (vblank) nxt = ST_ACT;
        ST_EXIT:  if (exit_done) nxt = ST_IDLE;
        default:  nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_OFF;
      in_trans_q <= 1'b0;
      active_q   <= 1'b0;
      wake_q     <= 1'b0;
    end else begin
      state_q    <= nxt;
      in_trans_q <= is_transit(nxt);
      active_q   <= is_active(nxt);
      wake_q     <= wake_nxt;
    end
  end
endmodule

// File: rtl/psr_seq_top.sv
module psr_seq_top
  import psr_seq_pkg::*;
#(
  parameter int MODE_W     = 2,
  parameter int TIMER_CODE = 1,
  parameter int TMO_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic              wr_enable,
  input  logic              wr_entry,
  input  logic              wr_sfu,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              vblank,
  input  logic              wake_ack,
  input  logic [TMO_W-1:0]  timeout_frames,
  output logic [2:0]        state_code,
  output logic              in_transition,
  output logic              psr_active,
  output logic              wake_req,
  output logic              wake_timeout,
  output logic              rb_enable,
  output logic              rb_entry,
  output logic              rb_sfu,
  output logic [MODE_W-1:0] rb_mode
);
  localparam logic [MODE_W-1:0] TIMER_MODE = MODE_W'(TIMER_CODE);

  psr_state_e st;
  logic       dis_go;
  logic       sfu_done;
  logic       exit_done;

  psr_ctl_regs #(.MODE_W(MODE_W)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_enable(wr_enable),
    .wr_entry (wr_entry),
    .wr_sfu   (wr_sfu),
    .wr_mode  (wr_mode),
    .in_trans (in_transition),
    .sfu_done (sfu_done),
    .en_q     (rb_enable),
    .entry_q  (rb_entry),
    .sfu_q    (rb_sfu),
    .mode_q   (rb_mode),
    .dis_go   (dis_go)
  );

  psr_wake_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .in_exit  (st == ST_EXIT),
    .vblank   (vblank),
    .wake_ack (wake_ack),
    .limit    (timeout_frames),
    .exit_done(exit_done),
    .timeout_q(wake_timeout)
  );

  psr_state_core #(.MODE_W(MODE_W), .TIMER_MODE(TIMER_MODE)) u_core (
    .clk       (clk),
    .rst       (rst),
    .en        (rb_enable),
    .entry     (rb_entry),
    .sfu       (rb_sfu),
    .mode      (rb_mode),
    .vblank    (vblank),
    .dis_go    (dis_go),
    .exit_done (exit_done),
    .state_q   (st),
    .in_trans_q(in_transition),
    .active_q  (psr_active),
    .wake_q    (wake_req),
    .sfu_done  (sfu_done)
  );

  assign state_code = st;
endmodule

// File: rtl/psr_seq_chk.sv
module psr_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       vblank,
  input logic [2:0] state_code,
  input logic       in_transition,
  input logic       psr_active,
  input logic       wake_req,
  input logic       wake_timeout,
  input logic       rb_sfu
);
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    state_code <= 3'd5); // R11

  AST_ACTIVE_MATCH: assert property (@(posedge clk) disable iff (rst)
    psr_active == (state_code == 3'd3 || state_code == 3'd4)); // R9

  AST_TRANS_MATCH: assert property (@(posedge clk) disable iff (rst)
    in_transition == (state_code == 3'd2 || state_code == 3'd4 || state_code == 3'd5)); // R11

  AST_ENTRY_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
    ($past(state_code) == 3'd2 && state_code == 3'd3) |-> $past(vblank)); // R3

  AST_WAKE_IN_EXIT: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> (state_code == 3'd5 && $past(state_code) == 3'd3)); // R6

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wake_req |=> !wake_req); // R6

  AST_EXIT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(state_code) == 3'd5 && state_code != 3'd5) |-> state_code == 3'd1); // R7

  AST_SFU_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($past(state_code) == 3'd4 && state_code == 3'd3) |-> !rb_sfu); // R5

  AST_DISABLE_WAITS: assert property (@(posedge clk) disable iff (rst)
    (state_code == 3'd0 && $past(state_code) != 3'd0) |-> !$past(in_transition)); // R10

  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(wake_timeout) |-> wake_timeout); // R8
endmodule

bind psr_seq_top psr_seq_chk u_chk (.*);

// File: tb/tb_psr_seq_top.sv
module tb_psr_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int MODE_W = 2;
  localparam int TMO_W  = 8;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_VB = 2'd2, OP_ACK = 2'd3;

  // {op, en, entry, sfu, mode, exp_code, exp_trans, exp_active, exp_sfu}
  localparam int NV = 12;
  localparam logic [12:0] VEC [NV] = '{
    {OP_WR,  1'b1, 1'b0, 1'b0, 2'd1, 3'd1, 1'b0, 1'b0, 1'b0},
    {OP_WR,  1'b1, 1'b1, 1'b0, 2'd1, 3'd2, 1'b1, 1'b0, 1'b0},
    {OP_IDLE,1'b0, 1'b0, 1'b0, 2'd0, 3'd2, 1'b1, 1'b0, 1'b0},
    {OP_VB,  1'b0, 1'b0, 1'b0, 2'd0, 3'd3, 1'b0, 1'b1, 1'b0},
    {OP_WR,  1'b1, 1'b1, 1'b1, 2'd1, 3'd4, 1'b1, 1'b1, 1'b1},
    {OP_VB,  1'b0, 1'b0, 1'b0, 2'd0, 3'd3, 1'b0, 1'b1, 1'b0},
    {OP_WR,  1'b1, 1'b0, 1'b0, 2'd1, 3'd5, 1'b1, 1'b0, 1'b0},
    {OP_ACK, 1'b0, 1'b0, 1'b0, 2'd0, 3'd5, 1'b1, 1'b0, 1'b0},
    {OP_VB,  1'b0, 1'b0, 1'b0, 2'd0, 3'd1, 1'b0, 1'b0, 1'b0},
    {OP_WR,  1'b1, 1'b1, 1'b0, 2'd1, 3'd2, 1'b1, 1'b0, 1'b0},
    {OP_VB,  1'b0, 1'b0, 1'b0, 2'd0, 3'd3, 1'b0, 1'b1, 1'b0},
    {OP_WR,  1'b1, 1'b0, 1'b0, 2'd1, 3'd5, 1'b1, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst;
  logic wr_valid, wr_enable, wr_entry, wr_sfu;
  logic [MODE_W-1:0] wr_mode;
  logic vblank, wake_ack;
  logic [TMO_W-1:0] timeout_frames;
  logic [2:0] state_code;
  logic in_transition, psr_active, wake_req, wake_timeout;
  logic rb_enable, rb_entry, rb_sfu;
  logic [MODE_W-1:0] rb_mode;

  int checks = 0;
  int failures = 0;
  int wake_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psr_seq_top #(.MODE_W(MODE_W), .TMO_W(TMO_W)) dut (.*);

  always @(negedge clk) if (wake_req) wake_cnt++;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] op, logic en, logic ent, logic sfu, logic [1:0] md);
    @(negedge clk);
    wr_valid  = (op == OP_WR);
    wr_enable = en;
    wr_entry  = ent;
    wr_sfu    = sfu;
    wr_mode   = md;
    vblank    = (op == OP_VB);
    wake_ack  = (op == OP_ACK);
    @(negedge clk);
    wr_valid = 1'b0; vblank = 1'b0; wake_ack = 1'b0; wr_sfu = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    wr_valid = 0; wr_enable = 0; wr_entry = 0; wr_sfu = 0; wr_mode = '0;
    vblank = 0; wake_ack = 0; timeout_frames = 8'd4;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 code", state_code, 0);
    check("R1 flags", {in_transition, psr_active, wake_req, wake_timeout}, 0);
    check("R1 readback", {rb_enable, rb_entry, rb_sfu, rb_mode}, 0);

    // Vector walk covering R2 R3 R4 R5 R6 R7 R9 R11
    for (int i = 0; i < NV; i++) begin
      int w0;
      w0 = wake_cnt;
      apply(VEC[i][12:11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:6]);
      check($sformatf("R3/R5/R7 vec%0d code", i), state_code, VEC[i][5:3]);
      check($sformatf("R11 vec%0d in_transition", i), in_transition, VEC[i][2]);
      check($sformatf("R9 vec%0d psr_active", i), psr_active, VEC[i][1]);
      check($sformatf("R5 vec%0d rb_sfu", i), rb_sfu, VEC[i][0]);
      if (i == 6 || i == 11) check($sformatf("R6 vec%0d wake pulses", i), wake_cnt - w0, 1);
      else                   check($sformatf("R6 vec%0d no wake", i), wake_cnt - w0, 0);
    end

    // R7 / R8: no ack, limit 4 frames
    for (int k = 0; k < 3; k++) apply(OP_VB, 0, 0, 0, 0);
    check("R7 still exiting before limit", state_code, 5);
    check("R8 no timeout yet", wake_timeout, 0);
    apply(OP_VB, 0, 0, 0, 0);
    check("R8 return to inactive", state_code, 1);
    check("R8 timeout set", wake_timeout, 1);

    // R10 deferred disable
    apply(OP_WR, 1, 1, 0, 2'd1);
    check("R10 setup entering", state_code, 2);
    apply(OP_WR, 0, 0, 0, 2'd0);
    check("R10 disable deferred code", state_code, 2);
    check("R10 disable deferred enable", rb_enable, 1);
    apply(OP_VB, 0, 0, 0, 0);
    check("R10 disabled code", state_code, 0);
    check("R10 fields cleared", {rb_enable, rb_entry, rb_sfu, rb_mode}, 0);
    check("R8 timeout sticky", wake_timeout, 1);

    // R2 wrong mode
    apply(OP_WR, 1, 0, 0, 2'd2);
    check("R2 non-timer mode stays off", state_code, 0);
    check("R2 enable stored", rb_enable, 1);

    // R1 reset again
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 reset clears timeout", wake_timeout, 0);
    check("R1 reset readback", {rb_enable, rb_mode}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule